// File: doc/BRIEF.md
# Conditional Skip Sequencer

This block decides, for a small 16-bit processor, whether a conditional-test instruction lets the following instruction run. It is given the decoded opcode and the two resolved operand values, called b and a. When a test passes, nothing happens and the next instruction executes normally. When a test fails, the block requests one stall cycle. It then walks forward over the instruction that follows, telling the program counter how many words to step past it.

If the instruction being stepped over is itself a conditional, the walk continues. It carries on down any run of back-to-back conditionals until it has stepped over the first non-conditional instruction. During each skip cycle, the surrounding pipeline presents a short descriptor of the instruction at the current position: a flag saying whether it is a conditional, and its count of extra operand words (0 to 2). The block answers with the advance for that cycle.

While the block is stalling or skipping, it owns the sequencing and does not evaluate new instructions. Operand fetch, register file and memory lie outside it.

Top module: `cond_skip_unit`

## Requirements
- R1: Opcode 0x11 passes when the bitwise AND of b and a is all zeros. Opcode 0x10 passes when that AND has any bit set.
- R2: Opcode 0x13 passes when b and a differ. Opcode 0x12 passes when they are identical.
- R3: Opcode 0x16 passes when b is below a as unsigned values. Opcode 0x14 passes when b is above a as unsigned values.
- R4: Opcode 0x17 passes when b is below a as two's-complement values. Opcode 0x15 passes when b is above a as two's-complement values.
- R5: A presented instruction (inst_valid high while idle) that passes its test, or whose opcode lies outside 0x10..0x17, leaves stall_req and skip_active low on the following cycle.
- R6: A presented conditional whose test fails raises stall_req for exactly the one cycle after the presenting edge. skip_active stays low in that cycle.
- R7: In the cycle after the stall, and in every cycle of a skip, skip_active is high and skip_advance equals 1 plus next_extra_words (0..2). Exactly one instruction is stepped over per cycle.
- R8: During a skip cycle, next_is_cond high keeps skip_active high in the following cycle. next_is_cond low ends the skip, so that stall_req and skip_active are both low in the following cycle.
- R9: While stall_req or skip_active is high, inst_valid, opcode and operands are ignored, so a failing conditional presented then starts no second stall.
- R10: After reset, stall_req, skip_active and skip_advance are all zero.
- R11: Whenever skip_active is low, skip_advance is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inst_valid | input | 1 | An instruction is presented for evaluation this cycle |
| opcode | input | 5 | Decoded opcode of the presented instruction |
| op_b | input | 16 | Resolved value of operand b |
| op_a | input | 16 | Resolved value of operand a |
| next_is_cond | input | 1 | The instruction at the current skip position is a conditional |
| next_extra_words | input | 2 | Operand words carried by that instruction (0..2) |
| stall_req | output | 1 | One-cycle penalty request after a failed test |
| skip_active | output | 1 | The instruction at the current position is being skipped |
| skip_advance | output | 2 | Words to add to the program counter this cycle |

## Verification
A wrong sequencing state shows up at the ports within one clock. An evaluation that is lost or spurious appears as a stall_req that is missing or unexpected on the cycle right after presentation. A chain handled wrongly appears as skip_active dropping early, or lingering one cycle after a non-conditional was stepped over. Comparator mistakes are most visible where signed and unsigned orderings disagree (b = 0x8000 against a = 0x7FFF) and on equal operands. These cases are aimed at directly, alongside seeded random operands and chain lengths. Each skip cycle's advance is compared against the descriptor presented in that same cycle.

// File: rtl/cond_skip_pkg.sv
package cond_skip_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_STALL = 2'd1,
    SEQ_SKIP  = 2'd2
  } seqState_t;

  // strobes from sequencing control towards the datapath
  typedef struct packed {
    logic evalEn;
    logic stallOut;
    logic skipOut;
  } skipStrobe_t;

  // low three opcode bits select the comparison
  typedef enum logic [2:0] {
    TST_ANY_SET  = 3'd0,
    TST_NONE_SET = 3'd1,
    TST_EQ       = 3'd2,
    TST_NE       = 3'd3,
    TST_GT_U     = 3'd4,
    TST_GT_S     = 3'd5,
    TST_LT_U     = 3'd6,
    TST_LT_S     = 3'd7
  } testSel_t;

  localparam int unsigned NUM_TESTS = 8;

endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import cond_skip_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opA,
  input  logic [2:0]        testSel,
  output logic              pass
);

  logic [NUM_TESTS-1:0] passVec;
  logic [DATA_W-1:0]    andVal;

  assign andVal = opB & opA;

  for (genvar t = 0; t < NUM_TESTS; t++) begin : g_test
    if (t == int'(TST_ANY_SET)) begin : g_any
      assign passVec[t] = |andVal;
    end else if (t == int'(TST_NONE_SET)) begin : g_none
      assign passVec[t] = ~(|andVal);
    end else if (t == int'(TST_EQ)) begin : g_eq
      assign passVec[t] = (opB == opA);
    end else if (t == int'(TST_NE)) begin : g_ne
      assign passVec[t] = (opB != opA);
    end else if (t == int'(TST_GT_U)) begin : g_gtu
      assign passVec[t] = (opB > opA);
    end else if (t == int'(TST_GT_S)) begin : g_gts
      assign passVec[t] = ($signed(opB) > $signed(opA));
    end else if (t == int'(TST_LT_U)) begin : g_ltu
      assign passVec[t] = (opB < opA);
    end else begin : g_lts
      assign passVec[t] = ($signed(opB) < $signed(opA));
    end
  end

  assign pass = passVec[testSel];

endmodule

// File: rtl/cond_skip_datapath.sv
module cond_skip_datapath
  import cond_skip_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned OPC_W     = 5,
  parameter int unsigned COND_BASE = 16,
  parameter int unsigned MAX_EXTRA = 2,
  localparam int unsigned EXTRA_W  = $clog2(MAX_EXTRA + 1),
  localparam int unsigned ADV_W    = $clog2(MAX_EXTRA + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  skipStrobe_t        strobe,
  input  logic [OPC_W-1:0]   opcode,
  input  logic [DATA_W-1:0]  opB,
  input  logic [DATA_W-1:0]  opA,
  input  logic [EXTRA_W-1:0] nextExtraWords,
  output logic               condFail,
  output logic [ADV_W-1:0]   skipAdvance
);

  localparam logic [OPC_W-1:0] BASE_OPC = OPC_W'(COND_BASE);

  logic isCond;
  logic pass;

  assign isCond = (opcode[OPC_W-1:3] == BASE_OPC[OPC_W-1:3]);

  cond_eval #(.DATA_W(DATA_W)) eval_i (
    .opB    (opB),
    .opA    (opA),
    .testSel(opcode[2:0]),
    .pass   (pass)
  );

  assign condFail = isCond & ~pass;

  always_comb begin
    skipAdvance = '0;
    if (strobe.skipOut) begin
      skipAdvance = ADV_W'(1) + ADV_W'(nextExtraWords);
    end
  end

  // R2: equal operands never fail the equality test
  a_r2_eq_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == BASE_OPC + OPC_W'(2) && opB == opA) |-> !condFail);

  // R1: disjoint operands always fail the any-bit-set test
  a_r1_and_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == BASE_OPC && (opB & opA) == '0) |-> condFail);

  // R11: no advance outside a skip
  a_r11_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.skipOut |-> skipAdvance == '0);

  // R7: advance during a skip spans one to MAX_EXTRA+1 words
  a_r7_advance_range: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.skipOut && nextExtraWords <= EXTRA_W'(MAX_EXTRA)) |->
      (skipAdvance != '0 && skipAdvance <= ADV_W'(MAX_EXTRA + 1)));

endmodule

// File: rtl/cond_skip_control.sv
module cond_skip_control
  import cond_skip_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instValid,
  input  logic        condFail,
  input  logic        nextIsCond,
  output skipStrobe_t strobe
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      SEQ_IDLE:  if (instValid && condFail) stateD = SEQ_STALL;
      SEQ_STALL: stateD = SEQ_SKIP;
      SEQ_SKIP:  if (!nextIsCond) stateD = SEQ_IDLE;
      default:   stateD = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= SEQ_IDLE;
    else        stateQ <= stateD;
  end

  assign strobe.evalEn   = instValid && (stateQ == SEQ_IDLE);
  assign strobe.stallOut = (stateQ == SEQ_STALL);
  assign strobe.skipOut  = (stateQ == SEQ_SKIP);

  // R6: a failure seen while idle is followed by the penalty cycle
  a_r6_fail_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && condFail && !strobe.stallOut && !strobe.skipOut) |=> strobe.stallOut);

  // R6: the penalty lasts one cycle and hands over to skipping
  a_r6_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stallOut |=> (strobe.skipOut && !strobe.stallOut));

  // R5: a pass or non-conditional while idle starts nothing
  a_r5_pass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.stallOut && !strobe.skipOut && !(instValid && condFail)) |=>
      (!strobe.stallOut && !strobe.skipOut));

  // R8: a conditional under the skip keeps the skip going
  a_r8_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.skipOut && nextIsCond) |=> strobe.skipOut);

  // R8: a non-conditional under the skip ends it
  a_r8_end: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.skipOut && !nextIsCond) |=> (!strobe.skipOut && !strobe.stallOut));

  // R9: never stalling and skipping together
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.stallOut && strobe.skipOut));

endmodule

// File: rtl/cond_skip_unit.sv
module cond_skip_unit
  import cond_skip_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned OPC_W     = 5,
  parameter int unsigned COND_BASE = 16,
  parameter int unsigned MAX_EXTRA = 2,
  localparam int unsigned EXTRA_W  = $clog2(MAX_EXTRA + 1),
  localparam int unsigned ADV_W    = $clog2(MAX_EXTRA + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inst_valid,
  input  logic [OPC_W-1:0]   opcode,
  input  logic [DATA_W-1:0]  op_b,
  input  logic [DATA_W-1:0]  op_a,
  input  logic               next_is_cond,
  input  logic [EXTRA_W-1:0] next_extra_words,
  output logic               stall_req,
  output logic               skip_active,
  output logic [ADV_W-1:0]   skip_advance
);

  skipStrobe_t strobe;
  logic        condFail;

  cond_skip_control ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .instValid (inst_valid),
    .condFail  (condFail),
    .nextIsCond(next_is_cond),
    .strobe    (strobe)
  );

  cond_skip_datapath #(
    .DATA_W   (DATA_W),
    .OPC_W    (OPC_W),
    .COND_BASE(COND_BASE),
    .MAX_EXTRA(MAX_EXTRA)
  ) dp_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (strobe),
    .opcode        (opcode),
    .opB           (op_b),
    .opA           (op_a),
    .nextExtraWords(next_extra_words),
    .condFail      (condFail),
    .skipAdvance   (skip_advance)
  );

  assign stall_req   = strobe.stallOut;
  assign skip_active = strobe.skipOut;

endmodule

// File: tb/cond_skip_unit_tb_top.sv
`timescale 1ns/1ps
module cond_skip_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inst_valid = 1'b0;
  logic [4:0]  opcode = '0;
  logic [15:0] op_b = '0;
  logic [15:0] op_a = '0;
  logic        next_is_cond = 1'b0;
  logic [1:0]  next_extra_words = '0;
  logic        stall_req;
  logic        skip_active;
  logic [1:0]  skip_advance;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cond_skip_unit dut_i (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .opcode(opcode),
    .op_b(op_b), .op_a(op_a), .next_is_cond(next_is_cond),
    .next_extra_words(next_extra_words), .stall_req(stall_req),
    .skip_active(skip_active), .skip_advance(skip_advance)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit isCondOp(input logic [4:0] opc);
    return opc >= 5'h10 && opc <= 5'h17;
  endfunction

  function automatic bit expPass(input logic [4:0] opc, input logic [15:0] b, input logic [15:0] a);
    int sb = int'($signed(b));
    int sa = int'($signed(a));
    case (opc)
      5'h10: return (b & a) != 16'h0;
      5'h11: return (b & a) == 16'h0;
      5'h12: return b == a;
      5'h13: return b != a;
      5'h14: return int'(b) > int'(a);
      5'h15: return sb > sa;
      5'h16: return int'(b) < int'(a);
      5'h17: return sb < sa;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string reqFor(input logic [4:0] opc);
    case (opc)
      5'h10, 5'h11: return "R1";
      5'h12, 5'h13: return "R2";
      5'h14, 5'h16: return "R3";
      5'h15, 5'h17: return "R4";
      default:      return "R5";
    endcase
  endfunction

  // present one instruction; on failure, step over a chain of 'chain' conditionals plus one
  task automatic runOne(input logic [4:0] opc, input logic [15:0] b, input logic [15:0] a, input int chain);
    bit fail;
    @(negedge clk);
    inst_valid = 1'b1; opcode = opc; op_b = b; op_a = a;
    next_is_cond = 1'($urandom); next_extra_words = 2'($urandom % 3);
    fail = isCondOp(opc) && !expPass(opc, b, a);
    @(negedge clk);
    if (fail) begin
      // R9: a failing conditional offered during the stall must be ignored
      inst_valid = 1'b1; opcode = 5'h12; op_b = 16'h1; op_a = 16'h2;
      chk(reqFor(opc), "stall after failed test", int'(stall_req), 1);
      chk("R6", "no skip during stall", int'(skip_active), 0);
      for (int i = 0; i <= chain; i++) begin
        @(negedge clk);
        next_is_cond = (i < chain);
        next_extra_words = 2'($urandom % 3);
        inst_valid = 1'b1; opcode = 5'h13; op_b = 16'h5; op_a = 16'h5;
        #1;
        chk("R7", "skip active", int'(skip_active), 1);
        chk("R9", "no restall while skipping", int'(stall_req), 0);
        chk("R7", "skip advance", int'(skip_advance), 1 + int'(next_extra_words));
      end
      @(negedge clk);
      inst_valid = 1'b0;
      chk("R8", "skip ended", int'(skip_active), 0);
      chk("R8", "no stall after skip", int'(stall_req), 0);
    end else begin
      inst_valid = 1'b0;
      chk(reqFor(opc), "no stall on pass", int'(stall_req), 0);
      chk("R5", "no skip on pass", int'(skip_active), 0);
      chk("R11", "zero advance when idle", int'(skip_advance), 0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R10", "stall in reset", int'(stall_req), 0);
    chk("R10", "skip in reset", int'(skip_active), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "advance after reset", int'(skip_advance), 0);
    chk("R10", "skip after reset", int'(skip_active), 0);

    // directed corners
    runOne(5'h10, 16'hF0F0, 16'h0F0F, 2);  // R1 fail, chain of two
    runOne(5'h10, 16'hF1F0, 16'h0F0F, 0);  // R1 pass
    runOne(5'h11, 16'hF0F0, 16'h0F0F, 0);  // R1 pass
    runOne(5'h12, 16'h1234, 16'h1234, 1);  // R2 pass
    runOne(5'h13, 16'h1234, 16'h1234, 1);  // R2 fail
    runOne(5'h14, 16'h8000, 16'h7FFF, 0);  // R3 pass unsigned
    runOne(5'h15, 16'h8000, 16'h7FFF, 1);  // R4 fail signed
    runOne(5'h17, 16'h8000, 16'h0001, 0);  // R4 pass signed
    runOne(5'h16, 16'h4444, 16'h4444, 3);  // R3 fail on equal
    runOne(5'h01, 16'h0000, 16'hFFFF, 0);  // R5 non-conditional
    runOne(5'h18, 16'h0001, 16'h0002, 0);  // R5 just past the range

    for (int n = 0; n < 400; n++) begin
      logic [4:0]  opc = 5'(5'h0E + ($urandom % 12));
      logic [15:0] b = 16'($urandom);
      logic [15:0] a = ($urandom % 4 == 0) ? b : 16'($urandom);
      runOne(opc, b, a, int'($urandom % 4));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule